// File: doc/BRIEF.md
# Programmable PWM Ramp Sequencer

The block drives a set of pulse-width-modulated output pins. Each pin's intensity comes from a small stored program rather than from one compare register. Every channel owns a 64-word instruction store of 16-bit words. A host loads the store through a byte-wide write port, sending the high byte of each word first and then its low byte. While a channel is enabled, it steps through its program. Instructions can ramp an 8-bit level up or down one LSB at a time with a programmable step time, load a level directly, snap the level to a rail, or jump back to word 0.

A shared 8-bit counter advances once per base tick (every `TICK_DIV` clocks) and wraps at 0xFF. Each pin is high while its channel is enabled and its level is greater than or equal to that counter. The host writes the per-channel enable bits at address 0. Channel `c` takes its instruction bytes at address `c+1`. Clearing an enable bit holds the level, forces the pin low and rewinds that channel's write pointer. Setting the bit starts execution at word 0.

Instruction word layout:
- **Branch:** bit 15 and bit 13 are both 1.
- **Load:** bit 15 is 1 and bit 13 is 0. Bits 7:0 hold the level.
- **Ramp:** bit 15 is 0. Bit 14 selects the slow prescaler, bits 13:8 give the step time in prescaled ticks, bit 7 is the direction and bits 6:0 the step count.

Top module: `pwm_ramp_seq`

## Requirements
- R1: The shared counter `pwm_cnt_o` is 0 after reset and rises by one every `TICK_DIV` clocks, wrapping from 0xFF to 0x00.
- R2: `pwm_o[c]` is 1 exactly when channel `c` is enabled and its level is greater than or equal to `pwm_cnt_o`.
- R3: A write to address 0 sets channel `c`'s enable from data bit `c` (bits 0..2). Enabling a channel starts its program at word 0, and other channels are unaffected.
- R4: A word is formed from two byte writes to address `c+1`, high byte first. It is stored at the channel's write pointer, which then advances and wraps from 63 to 0.
- R5: A ramp word (bit 15 = 0) with nonzero step time `s` (bits 13:8) and count `n` (bits 6:0) changes the level by one LSB `n` times. It moves up when bit 7 = 0 and down when bit 7 = 1. Steps are `s*D*TICK_DIV` clocks apart, where `D` is `SLOW_DIV` if bit 14 = 1 and `FAST_DIV` otherwise.
- R6: During ramps the level saturates at 0xFF going up and at 0x00 going down, with no wrap.
- R7: A branch word (bits 15 and 13 both 1) and the word 0x0000 restart execution at word 0.
- R8: A load word (bit 15 = 1, bit 13 = 0) writes its bits 7:0 into the level in one step.
- R9: A ramp word with step time 0 and nonzero count sets the level to 0x00 if bit 7 = 0 (e.g. 0x007F) and to 0xFF if bit 7 = 1 (e.g. 0x00FF).
- R10: While a channel is disabled, its pin is low and its level holds. Clearing its enable bit also resets its write pointer to word 0 and drops any pending high byte.
- R11: After reset all levels, enables and pins are 0, and every program word is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Byte write strobe |
| host_addr | input | HAW (2) | 0 = enable register, c+1 = channel c instruction port |
| host_data | input | 8 | Write data byte |
| pwm_o | output | NCH (3) | PWM pins, one per channel |
| level_o | output | 8*NCH (24) | Current level of each channel, channel c at bits 8c+7:8c |
| pwm_cnt_o | output | 8 | Shared PWM counter |

## Verification
On every cycle, the assertions check these properties:
- The counter advances only on a base tick.
- A ramp step never moves the level by more than one LSB, and it never wraps past a rail.
- A load lands its byte in the level.
- A branch returns the program counter to word 0, and enabling a channel starts it there.
- A disabled channel holds its level.
- Clearing an enable bit rewinds the write pointer.

Only the bench's scenarios can show the following, because they depend on the whole program flow:
- The spacing in clocks between ramp steps for both prescalers.
- The full level sequence of a looping program.
- The wrap of the write pointer after 64 words.
- Pointer rewind placing a new program at word 0.
- The exact pin waveform against the counter.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int LEVEL_W = 8;
  localparam int WORD_W  = 16;
  localparam int STEP_FW = 6;   // step-time field width, bits 13:8

  typedef enum logic [2:0] {
    K_START,   // 0x0000 style: restart at word 0
    K_BRANCH,  // bits 15 and 13 set
    K_LOAD,    // bit 15 set, bit 13 clear
    K_RAIL,    // ramp with zero step time, nonzero count
    K_SKIP,    // ramp with nonzero step time, zero count
    K_RAMP     // timed ramp
  } op_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_STEP} eng_state_e;

  function automatic op_kind_e decode_op(input logic [WORD_W-1:0] w);
    if (w[15] && w[13]) return K_BRANCH;
    if (w[15])          return K_LOAD;
    if (w[13:8] == '0) begin
      if (w[6:0] == '0) return K_START;
      return K_RAIL;
    end
    if (w[6:0] == '0)   return K_SKIP;
    return K_RAMP;
  endfunction

  // base ticks between two ramp steps
  function automatic int unsigned step_ticks(input logic slow,
                                             input logic [STEP_FW-1:0] steps,
                                             input int unsigned fast_div,
                                             input int unsigned slow_div);
    return int'(steps) * (slow ? slow_div : fast_div);
  endfunction

  // one-LSB move with saturation at both rails
  function automatic logic [LEVEL_W-1:0] nudge(input logic [LEVEL_W-1:0] lv,
                                               input logic down);
    if (down) return (lv == '0) ? lv : lv - 1'b1;
    return (lv == '1) ? lv : lv + 1'b1;
  endfunction

endpackage

// File: rtl/pwm_seq_timebase.sv
module pwm_seq_timebase #(
  parameter int TICK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tick_o,
  output logic [7:0] cnt_o
);

  localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_every_clk
      assign tick_o = 1'b1;
    end else begin : g_divided
      logic [TDW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          div_q <= '0;
        else if (div_q == TDW'(TICK_DIV-1))  div_q <= '0;
        else                                 div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == TDW'(TICK_DIV-1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_o) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_o == $past(cnt_o) + 8'd1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(cnt_o)); // R1

endmodule

// File: rtl/pwm_seq_progmem.sv
module pwm_seq_progmem
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic [7:0]        byte_in,
  input  logic              ptr_clr,
  input  logic [PW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr;
  logic              hi_pend;
  logic [7:0]        hi_q;
  logic              commit;

  assign commit = byte_wr && hi_pend && !ptr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      hi_pend <= 1'b0;
      hi_q    <= '0;
    end else if (ptr_clr) begin
      wptr    <= '0;
      hi_pend <= 1'b0;
    end else if (byte_wr) begin
      if (!hi_pend) begin
        hi_q    <= byte_in;
        hi_pend <= 1'b1;
      end else begin
        wptr    <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
        hi_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wptr] <= {hi_q, byte_in};
    end
  end

  assign rd_word = mem[rd_addr];

  AST_WPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (wptr == '0) && !hi_pend); // R10
  AST_WORD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !hi_pend && (wptr != $past(wptr))); // R4

endmodule

// File: rtl/pwm_seq_engine.sv
module pwm_seq_engine
  import pwm_seq_pkg::*;
#(
  parameter int PW       = 6,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 512,
  parameter int TW       = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [WORD_W-1:0]  word,
  output logic [PW-1:0]      pc_o,
  output logic [LEVEL_W-1:0] level_o
);

  eng_state_e  st;
  op_kind_e    kind;
  logic [6:0]  rem;
  logic [TW-1:0] timer, limit_q;
  logic        down_q;
  logic        step_now;

  assign kind     = decode_op(word);
  assign step_now = tick && (timer == limit_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pc_o    <= '0;
      level_o <= '0;
      rem     <= '0;
      timer   <= '0;
      limit_q <= '0;
      down_q  <= 1'b0;
    end else if (!en) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          pc_o <= '0;
          st   <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (kind)
            K_START, K_BRANCH: pc_o <= '0;
            K_LOAD: begin
              level_o <= word[7:0];
              pc_o    <= pc_o + 1'b1;
            end
            K_RAIL: begin
              level_o <= word[7] ? '1 : '0;
              pc_o    <= pc_o + 1'b1;
            end
            K_SKIP: pc_o <= pc_o + 1'b1;
            K_RAMP: begin
              rem     <= word[6:0];
              timer   <= '0;
              limit_q <= TW'(step_ticks(word[14], word[13:8], FAST_DIV, SLOW_DIV));
              down_q  <= word[7];
              st      <= ST_STEP;
            end
            default: pc_o <= '0;
          endcase
        end
        ST_STEP: begin
          if (step_now) begin
            timer   <= '0;
            level_o <= nudge(level_o, down_q);
            rem     <= rem - 1'b1;
            if (rem == 7'd1) begin
              pc_o <= pc_o + 1'b1;
              st   <= ST_EXEC;
            end
          end else if (tick) begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_RAMP_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP) |=> (level_o == $past(level_o)) ||
                        (level_o == $past(level_o) + 8'd1) ||
                        (level_o == $past(level_o) - 8'd1)); // R5
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP && !down_q && level_o == 8'hFF) |=> level_o == 8'hFF); // R6
  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP && down_q && level_o == 8'h00) |=> level_o == 8'h00); // R6
  AST_BRANCH_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_EXEC && (kind == K_BRANCH || kind == K_START)) |=> pc_o == '0); // R7
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_EXEC && kind == K_LOAD) |=> level_o == $past(word[7:0])); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(level_o)); // R10
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (pc_o == '0) && (st == ST_EXEC)); // R3

endmodule

// File: rtl/pwm_ramp_seq.sv
module pwm_ramp_seq
  import pwm_seq_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int PROG_DEPTH = 64,
  parameter int TICK_DIV   = 16,
  parameter int FAST_DIV   = 16,
  parameter int SLOW_DIV   = 512,
  localparam int HAW = $clog2(NCH + 1),
  localparam int PW  = $clog2(PROG_DEPTH),
  localparam int TW  = $clog2(63 * SLOW_DIV + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [HAW-1:0]       host_addr,
  input  logic [7:0]           host_data,
  output logic [NCH-1:0]       pwm_o,
  output logic [8*NCH-1:0]     level_o,
  output logic [7:0]           pwm_cnt_o
);

  logic           tick;
  logic [NCH-1:0] en_q;
  logic           ctrl_wr;
  logic [NCH-1:0] ptr_clr;

  pwm_seq_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick),
    .cnt_o  (pwm_cnt_o)
  );

  assign ctrl_wr = host_wr && (host_addr == '0);
  assign ptr_clr = ctrl_wr ? (en_q & ~host_data[NCH-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (ctrl_wr) en_q <= host_data[NCH-1:0];
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic              byte_wr;
      logic [WORD_W-1:0] word;
      logic [PW-1:0]     pc;
      logic [7:0]        level;

      assign byte_wr = host_wr && (host_addr == HAW'(c + 1));

      pwm_seq_progmem #(.DEPTH(PROG_DEPTH), .PW(PW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_wr (byte_wr),
        .byte_in (host_data),
        .ptr_clr (ptr_clr[c]),
        .rd_addr (pc),
        .rd_word (word)
      );

      pwm_seq_engine #(.PW(PW), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .TW(TW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q[c]),
        .tick    (tick),
        .word    (word),
        .pc_o    (pc),
        .level_o (level)
      );

      assign level_o[8*c +: 8] = level;
      assign pwm_o[c]          = en_q[c] && (level >= pwm_cnt_o);
    end
  endgenerate

endmodule

// File: tb/pwm_ramp_seq_bench.sv
module pwm_ramp_seq_bench;

  localparam int NCH = 3;
  localparam int TD  = 2;
  localparam int FD  = 2;
  localparam int SD  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_wr = 1'b0;
  logic [1:0]       host_addr = '0;
  logic [7:0]       host_data = '0;
  logic [NCH-1:0]   pwm_o;
  logic [8*NCH-1:0] level_o;
  logic [7:0]       pwm_cnt_o;

  int checks = 0, fails = 0;
  int cyc = 0, npos = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [NCH-1:0] en_model = '0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_ramp_seq #(.NCH(NCH), .PROG_DEPTH(64), .TICK_DIV(TD), .FAST_DIV(FD), .SLOW_DIV(SD))
    u_pwm_ramp_seq (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
                    .host_data(host_data), .pwm_o(pwm_o), .level_o(level_o),
                    .pwm_cnt_o(pwm_cnt_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lvl(input int ch);
    return level_o[ch*8 +: 8];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) npos++;
  end

  // per-cycle sweep: counter model (R1) and pin compare (R2, R10)
  always @(negedge clk) begin
    if (mon_on) begin
      check(pwm_cnt_o == 8'((npos / TD) % 256), "R1 counter", pwm_cnt_o, (npos / TD) % 256);
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = en_model[c] && (lvl(c) >= pwm_cnt_o);
        check(pwm_o[c] == e, "R2/R10 pin compare", pwm_o[c], e);
      end
    end
  end

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_data = d;
    @(posedge clk);
    #1;
    if (a == 2'd0) en_model = d[NCH-1:0];
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic put_word(input int ch, input logic [15:0] w);
    host_write(2'(ch + 1), w[15:8]);
    host_write(2'(ch + 1), w[7:0]);
  endtask

  task automatic set_en(input int ch, input bit v);
    logic [7:0] d;
    d = {5'd0, en_model};
    d[ch] = v;
    host_write(2'd0, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_change(input int ch, output logic [7:0] v, output int t);
    logic [7:0] prev;
    prev = lvl(ch);
    v = prev; t = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (lvl(ch) != prev) begin
        v = lvl(ch); t = cyc;
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [12];
    int         ts   [12];
    logic [7:0] exp_vals [12];
    bit         seen_rail, bad;
    int         hi_cnt;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(level_o == '0, "R11 levels after reset", level_o, 0);
    check(pwm_o == '0, "R11 pins after reset", pwm_o, 0);

    // R8 load then 0x0000 restart, channel 0 only enabled (R3)
    put_word(0, 16'h8040);
    put_word(0, 16'h0000);
    set_en(0, 1'b1);
    hi_cnt = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (pwm_o[1] || pwm_o[2]) hi_cnt++;
    end
    check(lvl(0) == 8'h40, "R8 load value", lvl(0), 8'h40);
    check(hi_cnt == 0, "R3 other channels stay off", hi_cnt, 0);

    // R9 rails, R10 hold and pointer rewind on channel 1
    put_word(1, 16'h00FF);
    put_word(1, 16'h0000);
    set_en(1, 1'b1);
    idle(10);
    check(lvl(1) == 8'hFF, "R9 rail high 0x00FF", lvl(1), 8'hFF);
    set_en(1, 1'b0);
    idle(300);
    check(lvl(1) == 8'hFF, "R10 level held while off", lvl(1), 8'hFF);
    check(pwm_o[1] == 1'b0, "R10 pin low while off", pwm_o[1], 0);
    put_word(1, 16'h007F);
    put_word(1, 16'h0000);
    set_en(1, 1'b1);
    idle(10);
    check(lvl(1) == 8'h00, "R9/R10 rail low at rewound word 0", lvl(1), 0);

    // R5 step spacing, R7 branch, R3 start at word 0 on channel 2
    put_word(2, 16'h8010);
    put_word(2, 16'h0305);
    put_word(2, 16'h4183);
    put_word(2, 16'hA000);
    exp_vals = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15,
                 8'h14, 8'h13, 8'h12, 8'h10, 8'h11, 8'h12};
    set_en(2, 1'b1);
    for (int i = 0; i < 12; i++) next_change(2, vals[i], ts[i]);
    for (int i = 0; i < 12; i++)
      check(vals[i] == exp_vals[i], "R5/R7/R3 level sequence", vals[i], exp_vals[i]);
    for (int i = 1; i < 5; i++)
      check(ts[i+1] - ts[i] == 3 * FD * TD, "R5 fast step spacing", ts[i+1] - ts[i], 3 * FD * TD);
    for (int i = 6; i < 8; i++)
      check(ts[i+1] - ts[i] == 1 * SD * TD, "R5 slow step spacing", ts[i+1] - ts[i], SD * TD);

    // R10 disable mid-ramp holds level
    idle(7);
    set_en(2, 1'b0);
    begin
      logic [7:0] held;
      held = lvl(2);
      idle(100);
      check(lvl(2) == held, "R10 hold mid-ramp", lvl(2), held);
    end

    // R6 saturation upward
    set_en(0, 1'b0);
    put_word(0, 16'h80FC);
    put_word(0, 16'h0108);
    put_word(0, 16'h0000);
    set_en(0, 1'b1);
    idle(4);
    seen_rail = 1'b0; bad = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (lvl(0) == 8'hFF) seen_rail = 1'b1;
      if (lvl(0) < 8'hFC) bad = 1'b1;
    end
    check(seen_rail, "R6 reaches 0xFF", seen_rail, 1);
    check(!bad, "R6 no wrap above 0xFF", bad, 0);

    // R6 saturation downward
    set_en(0, 1'b0);
    put_word(0, 16'h8003);
    put_word(0, 16'h0188);
    put_word(0, 16'h0000);
    set_en(0, 1'b1);
    idle(4);
    seen_rail = 1'b0; bad = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (lvl(0) == 8'h00) seen_rail = 1'b1;
      if (lvl(0) > 8'h03) bad = 1'b1;
    end
    check(seen_rail, "R6 reaches 0x00", seen_rail, 1);
    check(!bad, "R6 no wrap below 0x00", bad, 0);

    // R4 pointer wrap after 64 words, high byte first
    set_en(1, 1'b0);
    put_word(1, 16'h8055);
    for (int k = 1; k < 64; k++) put_word(1, 16'h0000);
    put_word(1, 16'h8077);
    set_en(1, 1'b1);
    idle(10);
    check(lvl(1) == 8'h77, "R4 65th word overwrites word 0", lvl(1), 8'h77);

    idle(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule